// File: doc/BRIEF.md
# Low-Leakage Interval Pair Matcher

This block holds a small programmable table of interval pairs for one kind of two-operand datapath unit. Each entry gives a closed range for the first operand and a closed range for the second. A lookup presents the operand ranges computed for a node. The block walks the table from index 0 upward, one entry per cycle. It stops at the first entry that overlaps the query on both operands and reports that entry's index.

If no entry overlaps, the block raises a control-point flag. It also returns a stored pair that a multiplexer in front of the unit can force while the datapath is idle. In first-usable mode the forced pair is the lowest-indexed usable entry. In random mode it is picked among the usable entries by a free-running shift register reduced modulo the number of usable entries. This random mode serves nodes fed straight from primary inputs.

The table is written through a simple address/data port while no lookup is running.

Top module: `llim_matcher`

## Requirements
- R1: After reset, busy, done, hit, cp_needed and force_valid are 0, and match_idx and force_idx are 0.
- R2: A table write (wr_en high) takes effect only while busy is 0; a write issued while busy is 1 is ignored. Writing with wr_keep = 0 removes the entry at wr_addr.
- R3: An entry overlaps a query when, for both operands, entry_lo <= query_hi and query_lo <= entry_hi, with values compared unsigned and endpoints included.
- R4: An interval whose lo exceeds its hi is empty. A query or entry holding an empty interval never matches, and an entry holding one is never offered as the forced pair.
- R5: A start accepted while busy is 0 makes busy 1 after that edge. The scan reports the lowest-indexed overlapping entry, with done, hit = 1 and match_idx = i, on the (i+1)-th clock edge after the accepting edge.
- R6: When no entry overlaps, done arrives on the DEPTH-th edge after the accepting edge with hit = 0 and cp_needed = 1. Exactly one of hit and cp_needed is 1 whenever done is 1.
- R7: In first-usable mode (rand_pick = 0 at start) a miss returns force_valid = 1 and the lowest-indexed usable entry, as force_idx together with its four bounds.
- R8: In random mode (rand_pick = 1 at start) a miss returns a usable entry's index and its bounds, chosen by a free-running LFSR value modulo the usable count. Repeated lookups do not always return the same entry when two or more are usable.
- R9: With no usable entry, a lookup ends in a miss with force_valid = 0 and all force bounds 0.
- R10: done is high for exactly one cycle. hit, cp_needed, match_idx and the force outputs hold until the next accepted start. A start raised while busy is 1 is ignored.
- R11: On a hit, force_valid is 0 and the force bounds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDX_W | Entry index to write |
| wr_keep | input | 1 | 1 stores the entry, 0 removes it |
| wr_a_lo | input | DATA_W | First-operand lower bound |
| wr_a_hi | input | DATA_W | First-operand upper bound |
| wr_b_lo | input | DATA_W | Second-operand lower bound |
| wr_b_hi | input | DATA_W | Second-operand upper bound |
| start | input | 1 | Begin a lookup |
| rand_pick | input | 1 | Miss replacement mode: 1 random, 0 first usable |
| q_a_lo | input | DATA_W | Query first-operand lower bound |
| q_a_hi | input | DATA_W | Query first-operand upper bound |
| q_b_lo | input | DATA_W | Query second-operand lower bound |
| q_b_hi | input | DATA_W | Query second-operand upper bound |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | An entry overlapped |
| cp_needed | output | 1 | No entry overlapped; control point required |
| match_idx | output | IDX_W | Index of the overlapping entry |
| force_valid | output | 1 | Force outputs hold a usable pair |
| force_idx | output | IDX_W | Index of the forced entry |
| force_a_lo | output | DATA_W | Forced first-operand lower bound |
| force_a_hi | output | DATA_W | Forced first-operand upper bound |
| force_b_lo | output | DATA_W | Forced second-operand lower bound |
| force_b_hi | output | DATA_W | Forced second-operand upper bound |

## Verification
The bench targets ranges that only touch at one endpoint. A design that used strict comparisons would miss these and report a control point where none is needed. It also targets queries that overlap on only one operand, which a design testing a single operand would wrongly accept.

Inverted ranges are stored so that the plain overlap formula would accept them. A design without the emptiness test would then hit, or would force an unusable pair.

The bench issues a write and a second start in mid-scan. A design that accepted either would change the table or the result. Random mode is run many times against a fixed set of usable entries, which catches a picker stuck on one index or one that lands on a removed entry. Hit latency is measured per index so that an off-by-one in the walk shows as a wrong cycle count.

// File: rtl/llim_pkg.sv
// Package: shared FSM encoding and shift-register defaults for the matcher.
// Assumes: nothing beyond IEEE 1800-2017.
package llim_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

    localparam int          LFSR_W_DEF    = 16;
    localparam logic [15:0] LFSR_TAPS_DEF = 16'hB400;
    localparam logic [15:0] LFSR_SEED_DEF = 16'hACE1;

endpackage

// File: rtl/llim_lfsr.sv
// Module: free-running Fibonacci shift register used as a random source.
// Assumes: TAPS gives a maximal sequence for WIDTH; SEED is nonzero.
module llim_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);
    logic feedback;

    // Parity of the tapped bits feeds the low end.
    always_comb feedback = ^(value & TAPS);

    // Advance every cycle, reloading the seed on reset or a stuck-at-zero state.
    always_ff @(posedge clk) begin
        if (!rst_n || value == '0) begin
            value <= SEED;
        end else begin
            value <= {value[WIDTH-2:0], feedback};
        end
    end
endmodule

// File: rtl/llim_table.sv
// Module: storage for DEPTH interval-pair entries with keep bits.
// An entry is usable when kept and both of its intervals are non-empty.
// Assumes: the caller gates wr_en so writes only occur while idle.
module llim_table #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic              wr_keep,
    input  logic [DATA_W-1:0] wr_a_lo,
    input  logic [DATA_W-1:0] wr_a_hi,
    input  logic [DATA_W-1:0] wr_b_lo,
    input  logic [DATA_W-1:0] wr_b_hi,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_usable,
    output logic [DATA_W-1:0] rd_a_lo,
    output logic [DATA_W-1:0] rd_a_hi,
    output logic [DATA_W-1:0] rd_b_lo,
    output logic [DATA_W-1:0] rd_b_hi,
    output logic [CNT_W-1:0]  usable_cnt
);
    logic [DEPTH-1:0]  keep_q;
    logic [DEPTH-1:0]  usable_vec;
    logic [DATA_W-1:0] a_lo_m [DEPTH];
    logic [DATA_W-1:0] a_hi_m [DEPTH];
    logic [DATA_W-1:0] b_lo_m [DEPTH];
    logic [DATA_W-1:0] b_hi_m [DEPTH];

    // Keep bits: cleared by reset, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else if (wr_en) begin
            keep_q[wr_addr] <= wr_keep;
        end
    end

    // Interval bounds: plain storage without reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            a_lo_m[wr_addr] <= wr_a_lo;
            a_hi_m[wr_addr] <= wr_a_hi;
            b_lo_m[wr_addr] <= wr_b_lo;
            b_hi_m[wr_addr] <= wr_b_hi;
        end
    end

    // Per-entry usability: kept and both intervals well formed.
    for (genvar g = 0; g < DEPTH; g++) begin : g_usable
        assign usable_vec[g] = keep_q[g]
                             && (a_lo_m[g] <= a_hi_m[g])
                             && (b_lo_m[g] <= b_hi_m[g]);
    end

    // Population count of usable entries.
    always_comb begin
        usable_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            usable_cnt = usable_cnt + CNT_W'(usable_vec[i]);
        end
    end

    // Read port addressed by the scan index.
    always_comb begin
        rd_usable = usable_vec[rd_idx];
        rd_a_lo   = a_lo_m[rd_idx];
        rd_a_hi   = a_hi_m[rd_idx];
        rd_b_lo   = b_lo_m[rd_idx];
        rd_b_hi   = b_hi_m[rd_idx];
    end
endmodule

// File: rtl/llim_overlap.sv
// Module: closed-interval pair intersection test.
// Overlap requires both operands to intersect and neither side to be empty.
// Assumes: unsigned bounds.
module llim_overlap #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] e_a_lo,
    input  logic [DATA_W-1:0] e_a_hi,
    input  logic [DATA_W-1:0] e_b_lo,
    input  logic [DATA_W-1:0] e_b_hi,
    input  logic [DATA_W-1:0] q_a_lo,
    input  logic [DATA_W-1:0] q_a_hi,
    input  logic [DATA_W-1:0] q_b_lo,
    input  logic [DATA_W-1:0] q_b_hi,
    output logic              overlap
);
    logic nonempty;
    logic meet_a;
    logic meet_b;

    // All four intervals must be well formed.
    always_comb nonempty = (e_a_lo <= e_a_hi) && (e_b_lo <= e_b_hi)
                        && (q_a_lo <= q_a_hi) && (q_b_lo <= q_b_hi);

    // Inclusive-endpoint intersection on each operand.
    always_comb begin
        meet_a = (e_a_lo <= q_a_hi) && (q_a_lo <= e_a_hi);
        meet_b = (e_b_lo <= q_b_hi) && (q_b_lo <= e_b_hi);
    end

    // Combined verdict.
    always_comb overlap = nonempty && meet_a && meet_b;
endmodule

// File: rtl/llim_scan_ctrl.sv
// Module: lookup sequencer. It captures the query on start, walks the table one
// entry per cycle, stops at the first overlap, and on a miss returns the
// chosen replacement pair.
// Assumes: the table does not change while busy; lfsr_val is free running.
module llim_scan_ctrl
    import llim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int LFSR_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rand_pick,
    input  logic [DATA_W-1:0] in_a_lo,
    input  logic [DATA_W-1:0] in_a_hi,
    input  logic [DATA_W-1:0] in_b_lo,
    input  logic [DATA_W-1:0] in_b_hi,
    input  logic [LFSR_W-1:0] lfsr_val,
    input  logic [CNT_W-1:0]  usable_cnt,
    input  logic              ent_usable,
    input  logic              ent_overlap,
    input  logic [DATA_W-1:0] ent_a_lo,
    input  logic [DATA_W-1:0] ent_a_hi,
    input  logic [DATA_W-1:0] ent_b_lo,
    input  logic [DATA_W-1:0] ent_b_hi,
    output logic [IDX_W-1:0]  scan_idx,
    output logic [DATA_W-1:0] qr_a_lo,
    output logic [DATA_W-1:0] qr_a_hi,
    output logic [DATA_W-1:0] qr_b_lo,
    output logic [DATA_W-1:0] qr_b_hi,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              cp_needed,
    output logic [IDX_W-1:0]  match_idx,
    output logic              force_valid,
    output logic [IDX_W-1:0]  force_idx,
    output logic [DATA_W-1:0] force_a_lo,
    output logic [DATA_W-1:0] force_a_hi,
    output logic [DATA_W-1:0] force_b_lo,
    output logic [DATA_W-1:0] force_b_hi
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    scan_state_t       state;
    logic [CNT_W-1:0]  target_ord;
    logic [CNT_W-1:0]  seen_cnt;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic [DATA_W-1:0] pick_a_lo, pick_a_hi, pick_b_lo, pick_b_hi;
    logic              pick_now;
    logic              accept;
    logic [LFSR_W-1:0] rand_mod;

    // A start is honoured only while idle.
    always_comb accept = (state == ST_IDLE) && start;

    // Ordinal of the usable entry to force in random mode.
    always_comb begin
        if (usable_cnt == '0) begin
            rand_mod = '0;
        end else begin
            rand_mod = lfsr_val % LFSR_W'(usable_cnt);
        end
    end

    // The current entry is the replacement when it is the target-th usable one.
    always_comb pick_now = (state == ST_SCAN) && ent_usable && !pick_found
                        && (seen_cnt == target_ord);

    always_comb busy = (state == ST_SCAN);

    // State, scan index and captured query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            scan_idx   <= '0;
            qr_a_lo    <= '0;
            qr_a_hi    <= '0;
            qr_b_lo    <= '0;
            qr_b_hi    <= '0;
            target_ord <= '0;
        end else if (accept) begin
            state      <= ST_SCAN;
            scan_idx   <= '0;
            qr_a_lo    <= in_a_lo;
            qr_a_hi    <= in_a_hi;
            qr_b_lo    <= in_b_lo;
            qr_b_hi    <= in_b_hi;
            target_ord <= rand_pick ? CNT_W'(rand_mod) : '0;
        end else if (state == ST_SCAN) begin
            if ((ent_usable && ent_overlap) || scan_idx == LAST_IDX) begin
                state <= ST_IDLE;
            end else begin
                scan_idx <= scan_idx + 1'b1;
            end
        end
    end

    // Replacement tracking while the walk is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            seen_cnt   <= '0;
            pick_found <= 1'b0;
            pick_idx   <= '0;
            pick_a_lo  <= '0;
            pick_a_hi  <= '0;
            pick_b_lo  <= '0;
            pick_b_hi  <= '0;
        end else if (state == ST_SCAN) begin
            if (ent_usable) begin
                seen_cnt <= seen_cnt + 1'b1;
            end
            if (pick_now) begin
                pick_found <= 1'b1;
                pick_idx   <= scan_idx;
                pick_a_lo  <= ent_a_lo;
                pick_a_hi  <= ent_a_hi;
                pick_b_lo  <= ent_b_lo;
                pick_b_hi  <= ent_b_hi;
            end
        end
    end

    // Result registers: loaded at the end of a scan, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            hit         <= 1'b0;
            cp_needed   <= 1'b0;
            match_idx   <= '0;
            force_valid <= 1'b0;
            force_idx   <= '0;
            force_a_lo  <= '0;
            force_a_hi  <= '0;
            force_b_lo  <= '0;
            force_b_hi  <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_SCAN && ent_usable && ent_overlap) begin
                done        <= 1'b1;
                hit         <= 1'b1;
                cp_needed   <= 1'b0;
                match_idx   <= scan_idx;
                force_valid <= 1'b0;
                force_idx   <= '0;
                force_a_lo  <= '0;
                force_a_hi  <= '0;
                force_b_lo  <= '0;
                force_b_hi  <= '0;
            end else if (state == ST_SCAN && scan_idx == LAST_IDX) begin
                done        <= 1'b1;
                hit         <= 1'b0;
                cp_needed   <= 1'b1;
                match_idx   <= '0;
                force_valid <= pick_found || pick_now;
                force_idx   <= pick_now ? scan_idx : pick_idx;
                force_a_lo  <= pick_now ? ent_a_lo : pick_a_lo;
                force_a_hi  <= pick_now ? ent_a_hi : pick_a_hi;
                force_b_lo  <= pick_now ? ent_b_lo : pick_b_lo;
                force_b_hi  <= pick_now ? ent_b_hi : pick_b_hi;
            end
        end
    end
endmodule

// File: rtl/llim_matcher.sv
// Module: top of the interval-pair matcher. It joins table, overlap test,
// random source and sequencer, and blocks table writes while a lookup runs.
// Assumes: synchronous active-low reset; DEPTH >= 2.
module llim_matcher
    import llim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int LFSR_W = LFSR_W_DEF,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = LFSR_TAPS_DEF,
    parameter logic [LFSR_W-1:0] LFSR_SEED = LFSR_SEED_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic              wr_keep,
    input  logic [DATA_W-1:0] wr_a_lo,
    input  logic [DATA_W-1:0] wr_a_hi,
    input  logic [DATA_W-1:0] wr_b_lo,
    input  logic [DATA_W-1:0] wr_b_hi,
    input  logic              start,
    input  logic              rand_pick,
    input  logic [DATA_W-1:0] q_a_lo,
    input  logic [DATA_W-1:0] q_a_hi,
    input  logic [DATA_W-1:0] q_b_lo,
    input  logic [DATA_W-1:0] q_b_hi,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              cp_needed,
    output logic [IDX_W-1:0]  match_idx,
    output logic              force_valid,
    output logic [IDX_W-1:0]  force_idx,
    output logic [DATA_W-1:0] force_a_lo,
    output logic [DATA_W-1:0] force_a_hi,
    output logic [DATA_W-1:0] force_b_lo,
    output logic [DATA_W-1:0] force_b_hi
);
    logic              tbl_we;
    logic [IDX_W-1:0]  scan_idx;
    logic              ent_usable;
    logic              ent_overlap;
    logic [DATA_W-1:0] ent_a_lo, ent_a_hi, ent_b_lo, ent_b_hi;
    logic [DATA_W-1:0] qr_a_lo, qr_a_hi, qr_b_lo, qr_b_hi;
    logic [CNT_W-1:0]  usable_cnt;
    logic [LFSR_W-1:0] lfsr_val;

    // Writes pass only while no lookup is running.
    always_comb tbl_we = wr_en && !busy;

    llim_table #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_addr(wr_addr), .wr_keep(wr_keep),
        .wr_a_lo(wr_a_lo), .wr_a_hi(wr_a_hi), .wr_b_lo(wr_b_lo), .wr_b_hi(wr_b_hi),
        .rd_idx(scan_idx), .rd_usable(ent_usable),
        .rd_a_lo(ent_a_lo), .rd_a_hi(ent_a_hi), .rd_b_lo(ent_b_lo), .rd_b_hi(ent_b_hi),
        .usable_cnt(usable_cnt)
    );

    llim_overlap #(.DATA_W(DATA_W)) u_overlap (
        .e_a_lo(ent_a_lo), .e_a_hi(ent_a_hi), .e_b_lo(ent_b_lo), .e_b_hi(ent_b_hi),
        .q_a_lo(qr_a_lo), .q_a_hi(qr_a_hi), .q_b_lo(qr_b_lo), .q_b_hi(qr_b_hi),
        .overlap(ent_overlap)
    );

    llim_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value(lfsr_val)
    );

    llim_scan_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LFSR_W(LFSR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rand_pick(rand_pick),
        .in_a_lo(q_a_lo), .in_a_hi(q_a_hi), .in_b_lo(q_b_lo), .in_b_hi(q_b_hi),
        .lfsr_val(lfsr_val), .usable_cnt(usable_cnt),
        .ent_usable(ent_usable), .ent_overlap(ent_overlap),
        .ent_a_lo(ent_a_lo), .ent_a_hi(ent_a_hi), .ent_b_lo(ent_b_lo), .ent_b_hi(ent_b_hi),
        .scan_idx(scan_idx),
        .qr_a_lo(qr_a_lo), .qr_a_hi(qr_a_hi), .qr_b_lo(qr_b_lo), .qr_b_hi(qr_b_hi),
        .busy(busy), .done(done), .hit(hit), .cp_needed(cp_needed),
        .match_idx(match_idx), .force_valid(force_valid), .force_idx(force_idx),
        .force_a_lo(force_a_lo), .force_a_hi(force_a_hi),
        .force_b_lo(force_b_lo), .force_b_hi(force_b_hi)
    );
endmodule

// File: rtl/llim_matcher_chk.sv
// Module: assertion checker for llim_matcher, attached by bind below.
// Assumes: synchronous active-low reset held for at least one edge.
module llim_matcher_chk #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic              cp_needed,
    input logic [IDX_W-1:0]  match_idx,
    input logic              force_valid,
    input logic [DATA_W-1:0] force_a_lo,
    input logic [DATA_W-1:0] force_a_hi,
    input logic [DATA_W-1:0] force_b_lo,
    input logic [DATA_W-1:0] force_b_hi
);
    logic rst_seen;
    logic out_seen;

    // Marks that a reset edge has occurred, and one clean cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen <= 1'b1;
            out_seen <= 1'b0;
        end else begin
            out_seen <= rst_seen;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && !out_seen) |-> (!busy && !done && !hit && !cp_needed && !force_valid));

    assert_start_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && start && !busy) |=> busy);

    assert_end_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_seen && $fell(busy)) |-> done);

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hit != cp_needed));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_seen && !busy && !$past(busy)) |->
            ($stable(hit) && $stable(cp_needed) && $stable(match_idx) && $stable(force_valid)));

    assert_force_on_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        force_valid |-> (cp_needed && !hit));

    assert_force_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        force_valid |-> ((force_a_lo <= force_a_hi) && (force_b_lo <= force_b_hi)));
endmodule

bind llim_matcher llim_matcher_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .hit(hit), .cp_needed(cp_needed), .match_idx(match_idx),
    .force_valid(force_valid),
    .force_a_lo(force_a_lo), .force_a_hi(force_a_hi),
    .force_b_lo(force_b_lo), .force_b_hi(force_b_hi)
);

// File: tb/tb_llim_matcher.sv
module tb_llim_matcher;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_addr = '0;
    logic              wr_keep = 1'b0;
    logic [DATA_W-1:0] wr_a_lo = '0, wr_a_hi = '0, wr_b_lo = '0, wr_b_hi = '0;
    logic              start = 1'b0;
    logic              rand_pick = 1'b0;
    logic [DATA_W-1:0] q_a_lo = '0, q_a_hi = '0, q_b_lo = '0, q_b_hi = '0;
    logic              busy, done, hit, cp_needed, force_valid;
    logic [IDX_W-1:0]  match_idx, force_idx;
    logic [DATA_W-1:0] force_a_lo, force_a_hi, force_b_lo, force_b_hi;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model of the table.
    bit        m_keep [DEPTH];
    int        m_alo [DEPTH], m_ahi [DEPTH], m_blo [DEPTH], m_bhi [DEPTH];

    always #4 clk = ~clk;

    llim_matcher #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_keep(wr_keep),
        .wr_a_lo(wr_a_lo), .wr_a_hi(wr_a_hi), .wr_b_lo(wr_b_lo), .wr_b_hi(wr_b_hi),
        .start(start), .rand_pick(rand_pick),
        .q_a_lo(q_a_lo), .q_a_hi(q_a_hi), .q_b_lo(q_b_lo), .q_b_hi(q_b_hi),
        .busy(busy), .done(done), .hit(hit), .cp_needed(cp_needed),
        .match_idx(match_idx), .force_valid(force_valid), .force_idx(force_idx),
        .force_a_lo(force_a_lo), .force_a_hi(force_a_hi),
        .force_b_lo(force_b_lo), .force_b_hi(force_b_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit usable(input int i);
        return m_keep[i] && m_alo[i] <= m_ahi[i] && m_blo[i] <= m_bhi[i];
    endfunction

    // R3/R4 reference: inclusive overlap on both operands, empty never matches.
    function automatic bit ref_overlap(input int i, input int al, input int ah,
                                       input int bl, input int bh);
        if (!usable(i) || al > ah || bl > bh) return 1'b0;
        return m_alo[i] <= ah && al <= m_ahi[i] && m_blo[i] <= bh && bl <= m_bhi[i];
    endfunction

    function automatic int first_hit(input int al, input int ah, input int bl, input int bh);
        for (int i = 0; i < DEPTH; i++) if (ref_overlap(i, al, ah, bl, bh)) return i;
        return -1;
    endfunction

    function automatic int first_usable();
        for (int i = 0; i < DEPTH; i++) if (usable(i)) return i;
        return -1;
    endfunction

    task automatic write_entry(input int addr, input bit keep, input int al, input int ah,
                               input int bl, input int bh);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IDX_W'(addr); wr_keep = keep;
        wr_a_lo = DATA_W'(al); wr_a_hi = DATA_W'(ah); wr_b_lo = DATA_W'(bl); wr_b_hi = DATA_W'(bh);
        @(negedge clk);
        wr_en = 1'b0;
        m_keep[addr] = keep;
        m_alo[addr] = al; m_ahi[addr] = ah; m_blo[addr] = bl; m_bhi[addr] = bh;
    endtask

    task automatic lookup(input int al, input int ah, input int bl, input int bh,
                          input bit rp, output int lat);
        @(negedge clk);
        start = 1'b1; rand_pick = rp;
        q_a_lo = DATA_W'(al); q_a_hi = DATA_W'(ah); q_b_lo = DATA_W'(bl); q_b_hi = DATA_W'(bh);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 4 * DEPTH);
    endtask

    // Compares one finished lookup with the model.
    task automatic expect_result(input int al, input int ah, input int bl, input int bh,
                                 input bit rp, input int lat);
        int eh;
        int fu;
        eh = first_hit(al, ah, bl, bh);
        chk(done == 1'b1, "R10 done", int'(done), 1);
        if (eh >= 0) begin
            chk(hit == 1'b1 && cp_needed == 1'b0, "R3 hit", int'(hit), 1);
            chk(int'(match_idx) == eh, "R5 match_idx", int'(match_idx), eh);
            chk(lat == eh + 1, "R5 latency", lat, eh + 1);
            chk(force_valid == 1'b0 && force_a_lo == '0 && force_b_hi == '0,
                "R11 force cleared", int'(force_valid), 0);
        end else begin
            fu = first_usable();
            chk(hit == 1'b0 && cp_needed == 1'b1, "R6 miss", int'(cp_needed), 1);
            chk(lat == DEPTH, "R6 latency", lat, DEPTH);
            if (fu < 0) begin
                chk(force_valid == 1'b0 && force_a_lo == '0 && force_a_hi == '0
                    && force_b_lo == '0 && force_b_hi == '0, "R9 empty table",
                    int'(force_valid), 0);
            end else if (!rp) begin
                chk(force_valid && int'(force_idx) == fu, "R7 force_idx", int'(force_idx), fu);
                chk(int'(force_a_lo) == m_alo[fu] && int'(force_a_hi) == m_ahi[fu]
                    && int'(force_b_lo) == m_blo[fu] && int'(force_b_hi) == m_bhi[fu],
                    "R7 force bounds", int'(force_a_lo), m_alo[fu]);
            end else begin
                chk(force_valid && usable(int'(force_idx)), "R8 usable pick",
                    int'(force_idx), fu);
                chk(int'(force_a_lo) == m_alo[force_idx] && int'(force_a_hi) == m_ahi[force_idx]
                    && int'(force_b_lo) == m_blo[force_idx] && int'(force_b_hi) == m_bhi[force_idx],
                    "R8 pick bounds", int'(force_a_lo), m_alo[force_idx]);
            end
        end
    endtask

    task automatic run(input int al, input int ah, input int bl, input int bh, input bit rp);
        int lat;
        lookup(al, ah, bl, bh, rp, lat);
        expect_result(al, ah, bl, bh, rp, lat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        int seen_mask;
        int npick;
        bit h0;
        bit c0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            m_keep[i] = 0; m_alo[i] = 0; m_ahi[i] = 0; m_blo[i] = 0; m_bhi[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !hit && !cp_needed && !force_valid && match_idx == '0
            && force_idx == '0, "R1 reset", int'(busy | done | hit | cp_needed), 0);
        rst_n = 1'b1;

        // R9: empty table
        run(0, 255, 0, 255, 1'b0);

        // R2: table load, R3/R5 hits
        write_entry(0, 1, 2, 4, 6, 8);
        write_entry(1, 1, 8, 12, 8, 12);
        write_entry(2, 1, 14, 20, 14, 24);
        run(8, 12, 8, 12, 1'b0);        // R5 hit entry 1
        run(16, 24, 20, 24, 1'b0);      // R5 hit entry 2
        run(0, 2, 8, 9, 1'b0);          // R3 endpoints touch entry 0
        run(2, 3, 30, 40, 1'b0);        // R3 one operand only, miss R7
        run(21, 30, 25, 40, 1'b0);      // R3 just past both ends of entry 2

        // R4: inverted entry that a plain formula would accept
        write_entry(3, 1, 50, 40, 0, 255);
        run(0, 60, 0, 5, 1'b0);
        run(10, 5, 0, 255, 1'b0);       // R4 inverted query
        write_entry(0, 0, 2, 4, 6, 8);  // R2 removal
        write_entry(1, 0, 8, 12, 8, 12);
        write_entry(2, 0, 14, 20, 14, 24);
        write_entry(5, 1, 30, 31, 32, 33);
        run(0, 1, 0, 1, 1'b0);          // R4/R7 forced pair skips entry 3, gives 5
        run(0, 1, 0, 1, 1'b1);          // R8 single usable entry

        // R10 hold, R2 write during busy, R10 start during busy
        write_entry(0, 1, 2, 4, 6, 8);
        @(negedge clk);
        start = 1'b1; rand_pick = 1'b0;
        q_a_lo = 8'd100; q_a_hi = 8'd110; q_b_lo = 8'd100; q_b_hi = 8'd110;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; q_a_lo = 8'd3; q_a_hi = 8'd3; q_b_lo = 8'd7; q_b_hi = 8'd7;
        wr_en = 1'b1; wr_addr = '0; wr_keep = 1'b1;
        wr_a_lo = 8'd200; wr_a_hi = 8'd201; wr_b_lo = 8'd200; wr_b_hi = 8'd201;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        lat = 2;
        while (!done && lat < 4 * DEPTH) begin
            @(negedge clk);
            lat++;
        end
        chk(done && cp_needed && !hit, "R10 start while busy ignored", int'(hit), 0);
        chk(lat == DEPTH, "R10 scan length unchanged", lat, DEPTH);
        h0 = hit; c0 = cp_needed;
        repeat (3) @(negedge clk);
        chk(!done && hit == h0 && cp_needed == c0 && force_valid, "R10 results held",
            int'(done), 0);
        run(3, 3, 7, 7, 1'b0);          // R2 entry 0 must still be [2,4]/[6,8]

        // R8: random pick spreads over usable entries
        write_entry(2, 1, 40, 41, 40, 41);
        write_entry(6, 1, 60, 61, 60, 61);
        seen_mask = 0;
        for (int k = 0; k < 24; k++) begin
            lookup(250, 251, 250, 251, 1'b1, lat);
            expect_result(250, 251, 250, 251, 1'b1, lat);
            seen_mask |= (1 << int'(force_idx));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        npick = $countones(seen_mask);
        chk(npick >= 2, "R8 spread", npick, 2);

        // Constrained random traffic
        for (int k = 0; k < 200; k++) begin
            int al, ah, bl, bh;
            if ($urandom_range(0, 2) == 0) begin
                int lo1, lo2;
                lo1 = $urandom_range(0, 60);
                lo2 = $urandom_range(0, 60);
                if ($urandom_range(0, 7) == 0)
                    write_entry($urandom_range(0, DEPTH - 1), 1'b1, lo1 + 5, lo1, lo2, lo2 + 3);
                else
                    write_entry($urandom_range(0, DEPTH - 1), $urandom_range(0, 7) != 0,
                                lo1, lo1 + $urandom_range(0, 6), lo2, lo2 + $urandom_range(0, 6));
            end
            al = $urandom_range(0, 66); ah = al + $urandom_range(0, 4);
            bl = $urandom_range(0, 66); bh = bl + $urandom_range(0, 4);
            if ($urandom_range(0, 15) == 0) ah = al - 1;
            if (al > ah) ah = al - 1;
            run(al, (ah < 0) ? 0 : ah, bl, bh, $urandom_range(0, 1) == 1);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule